// File: doc/BRIEF.md
# Dual-Port Synchronous Register File

This block is a small storage array of eight 8-bit words. It has one write port and one read port, and each port has its own address. Each port also has its own enable, so in any clock cycle the block can write, read, do both, or do neither. Writes land in the array on the rising clock edge. A read is also a clocked operation: on the edge, the selected word is captured into an output register, and the captured word stays on `rd_data` until the next enabled read or a reset.

The read and write ports may name the same word in the same cycle. In that case the output register takes the incoming write data (write-first forwarding), so the reader never sees the stale word. A synchronous reset clears only the output register. The array contents survive reset, and a write presented while reset is high still lands.

Top module: `dual_port_regfile`

## Requirements
- R1: When `rst` is high at a rising edge, `rd_data` becomes 0 after that edge whatever the read enable is, and the array contents are left unchanged by reset (a write with `wr_en` high during reset still lands).
- R2: When `wr_en` is high at a rising edge, the word at index `wr_addr` holds `wr_data` after that edge.
- R3: When `wr_en` is low at a rising edge, no word of the array changes, whatever `wr_addr` and `wr_data` carry.
- R4: When `rd_en` is high and `rst` is low at a rising edge, and there is no same-index write, `rd_data` shows the word held at index `rd_addr` before that edge, starting right after the edge.
- R5: When `rd_en` and `rst` are both low at a rising edge, `rd_data` keeps its previous value, even while writes change the word it came from.
- R6: When both enables are high at a rising edge and `rd_addr` equals `wr_addr`, `rd_data` shows the new `wr_data` after that edge.
- R7: When both enables are high at a rising edge and the indices differ, the read returns the old contents of its word and the write lands in its own word in the same edge.
- R8: A write changes only the addressed word; the other seven words keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock for both ports |
| rst | input | 1 | Synchronous active-high clear of the read output register |
| wr_en | input | 1 | Write enable |
| wr_addr | input | 3 | Index of the word to write |
| wr_data | input | 8 | Data to write |
| rd_en | input | 1 | Read enable; loads the output register |
| rd_addr | input | 3 | Index of the word to read |
| rd_data | output | 8 | Registered read data |

## Verification
The assertions assume that the enables, indices and write data are known, 0 or 1, at every edge once reset has been applied. They also assume that a word is read only after it has been written at least once, because the array has no reset value. The stimulus first writes every index, and only then starts reads. From then on it drives all inputs with defined values and changes them only on the falling clock edge, so the checks never sample an undefined word or an input that is still settling.

// File: rtl/rfile_pkg.sv
package rfile_pkg;

    localparam int unsigned RF_DEF_WORDS = 8;
    localparam int unsigned RF_DEF_WIDTH = 8;

    // Where the read output register takes its next value from
    typedef enum logic [1:0] {
        RD_SRC_HOLD   = 2'd0,
        RD_SRC_ARRAY  = 2'd1,
        RD_SRC_BYPASS = 2'd2,
        RD_SRC_CLEAR  = 2'd3
    } rd_src_e;

    // Pick the read source from reset, enables and the index match
    function automatic rd_src_e pick_rd_src(input logic clr,
                                            input logic rd_go,
                                            input logic wr_go,
                                            input logic same_idx);
        if (clr)
            return RD_SRC_CLEAR;
        else if (!rd_go)
            return RD_SRC_HOLD;
        else if (wr_go && same_idx)
            return RD_SRC_BYPASS;
        else
            return RD_SRC_ARRAY;
    endfunction

endpackage

// File: rtl/rf_wr_decode.sv
module rf_wr_decode #(
    parameter int unsigned NUM_WORDS = rfile_pkg::RF_DEF_WORDS,
    localparam int unsigned AW = $clog2(NUM_WORDS)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [AW-1:0]        wr_addr,
    output logic [NUM_WORDS-1:0] row_we
);

    for (genvar g = 0; g < NUM_WORDS; g++) begin : g_row
        assign row_we[g] = wr_en && (wr_addr == AW'(g));
    end

    AST_ROW_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(row_we)) else $error("several rows selected"); // R8

    AST_ROW_ON_WRITE: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> ($countones(row_we) == 1)) else $error("write selects no row"); // R2

endmodule

// File: rtl/rf_array.sv
module rf_array #(
    parameter int unsigned NUM_WORDS = rfile_pkg::RF_DEF_WORDS,
    parameter int unsigned DATA_W    = rfile_pkg::RF_DEF_WIDTH
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic [NUM_WORDS-1:0]              row_we,
    input  logic [DATA_W-1:0]                 wr_data,
    output logic [NUM_WORDS-1:0][DATA_W-1:0]  rows
);

    // Storage has no reset: contents survive rst
    for (genvar g = 0; g < NUM_WORDS; g++) begin : g_word
        always_ff @(posedge clk) begin
            if (row_we[g])
                rows[g] <= wr_data;
        end

        AST_ROW_KEEP: assert property (@(posedge clk) disable iff (rst)
            !row_we[g] |=> $stable(rows[g])) else $error("row changed without write"); // R3

        AST_ROW_LOAD: assert property (@(posedge clk) disable iff (rst)
            row_we[g] |=> (rows[g] == $past(wr_data))) else $error("row missed write"); // R2
    end

endmodule

// File: rtl/rf_read_port.sv
module rf_read_port
    import rfile_pkg::*;
#(
    parameter int unsigned NUM_WORDS = RF_DEF_WORDS,
    parameter int unsigned DATA_W    = RF_DEF_WIDTH,
    localparam int unsigned AW = $clog2(NUM_WORDS)
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              rd_en,
    input  logic [AW-1:0]                     rd_addr,
    input  logic                              wr_en,
    input  logic [AW-1:0]                     wr_addr,
    input  logic [DATA_W-1:0]                 wr_data,
    input  logic [NUM_WORDS-1:0][DATA_W-1:0]  rows,
    output logic [DATA_W-1:0]                 rd_data
);

    rd_src_e            src;
    logic               same_idx;
    logic [DATA_W-1:0]  arr_word;
    logic [DATA_W-1:0]  nxt;

    assign same_idx = (rd_addr == wr_addr);
    assign arr_word = rows[rd_addr];

    always_comb begin
        src = pick_rd_src(rst, rd_en, wr_en, same_idx);
        unique case (src)
            RD_SRC_CLEAR:  nxt = '0;
            RD_SRC_BYPASS: nxt = wr_data;
            RD_SRC_ARRAY:  nxt = arr_word;
            default:       nxt = rd_data;
        endcase
    end

    always_ff @(posedge clk) begin
        rd_data <= nxt;
    end

    AST_RST_CLEARS: assert property (@(posedge clk)
        rst |=> (rd_data == '0)) else $error("output not cleared"); // R1

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(rd_data)) else $error("output moved while idle"); // R5

    AST_COLLIDE_FWD: assert property (@(posedge clk) disable iff (rst)
        (rd_en && wr_en && (rd_addr == wr_addr)) |=> (rd_data == $past(wr_data)))
        else $error("collision not forwarded"); // R6

    AST_READ_OLD: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !(wr_en && (rd_addr == wr_addr))) |=> (rd_data == $past(rows[rd_addr])))
        else $error("read returned wrong word"); // R4

endmodule

// File: rtl/dual_port_regfile.sv
module dual_port_regfile #(
    parameter int unsigned NUM_WORDS = rfile_pkg::RF_DEF_WORDS,
    parameter int unsigned DATA_W    = rfile_pkg::RF_DEF_WIDTH,
    localparam int unsigned AW = $clog2(NUM_WORDS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [AW-1:0]     rd_addr,
    output logic [DATA_W-1:0] rd_data
);

    logic [NUM_WORDS-1:0]             row_we;
    logic [NUM_WORDS-1:0][DATA_W-1:0] rows;

    rf_wr_decode #(.NUM_WORDS(NUM_WORDS)) u_dec (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .row_we  (row_we)
    );

    rf_array #(.NUM_WORDS(NUM_WORDS), .DATA_W(DATA_W)) u_arr (
        .clk     (clk),
        .rst     (rst),
        .row_we  (row_we),
        .wr_data (wr_data),
        .rows    (rows)
    );

    rf_read_port #(.NUM_WORDS(NUM_WORDS), .DATA_W(DATA_W)) u_rd (
        .clk     (clk),
        .rst     (rst),
        .rd_en   (rd_en),
        .rd_addr (rd_addr),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rows    (rows),
        .rd_data (rd_data)
    );

    // R7: differing indices read the old word while the write lands elsewhere
    AST_SPLIT_RW: assert property (@(posedge clk) disable iff (rst)
        (rd_en && wr_en && (rd_addr != wr_addr)) |=> (rd_data == $past(rows[rd_addr])))
        else $error("split access disturbed read"); // R7

endmodule

// File: tb/tb_dual_port_regfile.sv
`timescale 1ns/1ps
module tb_dual_port_regfile;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       rd_en = 1'b0;
    logic [2:0] rd_addr = '0;
    logic [7:0] rd_data;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    int model_mem [8];
    int model_out;

    always #10 clk = ~clk;  // 50 MHz

    dual_port_regfile dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    task automatic check(input string req, input int actual, input int expected);
        checks++;
        if (actual != expected) begin
            errors++;
            $display("FAIL %s: rd_data=%0h expected=%0h at %0t", req, actual, expected, $time);
        end
    endtask

    // One cycle: drive at falling edge, model at rising edge, check at next falling edge
    task automatic step(input bit we, input int wa, input int wd,
                        input bit re, input int ra, input bit rs, input string req);
        wr_en = we; wr_addr = 3'(wa); wr_data = 8'(wd);
        rd_en = re; rd_addr = 3'(ra); rst = rs;
        @(posedge clk);
        if (rs)
            model_out = 0;
        else if (re)
            model_out = (we && wa == ra) ? wd : model_mem[ra];
        if (we)
            model_mem[wa] = wd;
        @(negedge clk);
        check(req, int'(rd_data), model_out);
    endtask

    task automatic readback(input string req);
        for (int i = 0; i < 8; i++)
            step(1'b0, 0, 0, 1'b1, i, 1'b0, req);
    endtask

    initial begin
        model_out = 0;
        for (int i = 0; i < 8; i++) model_mem[i] = 0;
        @(negedge clk);
        // R1: reset state, with writes filling the array during reset
        for (int i = 0; i < 8; i++)
            step(1'b1, i, 8'h10 + i * 3, 1'b1, 0, 1'b1, "R1");
        // R2: fill with distinct values, then read back every word
        for (int i = 0; i < 8; i++)
            step(1'b1, i, 8'hA0 + i, 1'b0, 0, 1'b0, "R2");
        readback("R2");
        // R4: reads in descending order
        for (int i = 7; i >= 0; i--)
            step(1'b0, 0, 0, 1'b1, i, 1'b0, "R4");
        // R5: output holds while idle, even when its source word is rewritten
        step(1'b0, 0, 0, 1'b1, 5, 1'b0, "R4");
        step(1'b1, 5, 8'h5C, 1'b0, 0, 1'b0, "R5");
        step(1'b0, 3, 8'hFF, 1'b0, 2, 1'b0, "R5");
        // R3: wr_en low with garbage on the write port
        for (int i = 0; i < 8; i++)
            step(1'b0, i, 8'hEE, 1'b0, 0, 1'b0, "R3");
        readback("R3");
        // R6: same-index collisions on every word
        for (int i = 0; i < 8; i++)
            step(1'b1, i, 8'h60 + i * 5, 1'b1, i, 1'b0, "R6");
        readback("R6");
        // R7: different indices, same cycle
        for (int i = 0; i < 8; i++)
            step(1'b1, i, 8'hC0 + i, 1'b1, (i + 1) % 8, 1'b0, "R7");
        readback("R7");
        // R8: single write leaves the rest untouched
        step(1'b1, 4, 8'h3E, 1'b0, 0, 1'b0, "R8");
        readback("R8");
        // R1: reset mid-run with rd_en high clears output, array retained
        step(1'b0, 0, 0, 1'b1, 4, 1'b1, "R1");
        step(1'b0, 0, 0, 1'b0, 4, 1'b0, "R1");
        readback("R1");
        // Mixed traffic
        for (int n = 0; n < 400; n++) begin
            automatic bit we = ($urandom % 3) != 0;
            automatic bit re = ($urandom % 3) != 0;
            automatic int wa = $urandom % 8;
            automatic int ra = (($urandom % 4) == 0) ? wa : $urandom % 8;
            automatic int wd = $urandom % 256;
            automatic string tag = !re ? "R5" : (we && wa == ra) ? "R6" : we ? "R7" : "R4";
            step(we, wa, wd, re, ra, 1'b0, tag);
        end
        readback("R8");
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #2000000;
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not complete");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule